// File: doc/BRIEF.md
# Programmable Power Sequencer

This block orders the resets and the pad supply of a power domain when it goes to sleep and when it comes back. It does not use fixed state machines. It runs two small stored programs, one for sleep and one for wakeup. Each program has eight instructions. An instruction waits a power-of-two number of clock cycles and then drives a new five-bit vector onto the control outputs. The controls are a clock-domain reset, a core reset, a pad reset, a pad-supply enable and one spare line.

A write of any value to the trigger register starts the sleep program. When the sleep program ends, the domain stays asleep until a wake event arrives whose bit is set in the wake mask. That event starts the wakeup program, and the masked event bits are kept in a cause register.

Every register write is protected by a key. First the key value is written to the key register, which arms a one-shot unlock. The next write then uses up that unlock.

Top module: `pwr_seq_top`

Word address map (reg_addr):

| Address | Register |
|---|---|
| 0 to 7 | sleep instructions 0 to 7 |
| 8 to 15 | wake instructions 0 to 7 |
| 16 | key; reads return the unlock state in bit 0 |
| 17 | sleep trigger |
| 18 | wake mask |
| 19 | wake cause, read-only |

Any other address reads 0.

## Requirements
- R1: After reset, the outputs have clkdom_rst, core_rst and pad_rst at 0, and pad_pwr_en and spare_ctl at 1. Both busy and asleep are 0, and the unlock bit is 0.
- R2: An instruction is 9 bits wide. Bits 3:0 hold the delay exponent. Bits 8:4 hold the output vector, in this order: bit 8 clkdom_rst, bit 7 core_rst, bit 6 pad_rst, bit 5 pad_pwr_en, bit 4 spare_ctl. Instruction bits 31:9 are not stored and read back as 0.
- R3: An instruction changes the outputs 2^exponent clock edges after the previous instruction took effect. For the first instruction, the count starts from the edge that starts the program. An exponent of 0 therefore waits exactly one cycle.
- R4: After reset, the sleep program holds 0x0f0, 0x1f0, 0x1d0, then 0x1c0 in entries 3 to 7. The wake program holds 0x1f0, 0x0f8, then 0x030 in entries 2 to 7.
- R5: Writing 0x0051F15E to the key address sets the unlock bit. Writing any other value to the key address clears it. Any write to another address clears it, whether or not that write is accepted.
- R6: A write to any address other than the key address is ignored while the unlock bit is 0.
- R7: An accepted trigger write, with any data, while the domain is awake and idle starts the sleep program. The program runs entries 0 to 7 in order, with busy at 1. At its end, busy goes to 0 and asleep goes to 1.
- R8: A trigger write that arrives while a program runs, or while the domain is asleep, is ignored.
- R9: While asleep, an event bit that is also set in the wake mask starts the wakeup program. The cause register then holds wake_evt AND mask, with bit i standing for event i. Event bits that are masked off have no effect.
- R10: The wakeup program runs entries 0 to 7 in order, with busy at 1, and then returns the domain to awake (busy and asleep both 0).
- R11: Wake events while the domain is not asleep are ignored. They leave the outputs and the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for writes and for reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wake_evt | input | 8 | Wake event lines, level sensitive |
| clkdom_rst | output | 1 | Clock-domain reset |
| core_rst | output | 1 | Core reset |
| pad_rst | output | 1 | Pad reset |
| pad_pwr_en | output | 1 | Pad-supply enable |
| spare_ctl | output | 1 | Reserved control line |
| asleep | output | 1 | Domain is asleep |
| busy | output | 1 | A program is running |

## Verification
The hardest condition to reach is a stray trigger or wake event that arrives in the middle of a long program step. To hit it, the bench loads a sleep program whose delays reach 32 cycles. While that program runs, it sends a keyed trigger write and raises the enabled event lines. The scoreboard already holds the exact edge and vector of every expected output change, so any restart or early wakeup shows up as a change that does not match. A second case puts the trigger and the events on a domain that is already asleep, with one event masked off.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int PROG_LEN = 8;
  localparam int PIDX_W   = $clog2(PROG_LEN);
  localparam int EXP_W    = 4;
  localparam int VEC_W    = 5;
  localparam int INSTR_W  = EXP_W + VEC_W;
  localparam int CNT_W    = 1 << EXP_W;

  localparam int A_SLEEP0 = 0;
  localparam int A_WAKE0  = PROG_LEN;
  localparam int A_KEY    = 2 * PROG_LEN;
  localparam int A_TRIG   = A_KEY + 1;
  localparam int A_MASK   = A_KEY + 2;
  localparam int A_CAUSE  = A_KEY + 3;

  // awake outputs: resets released, pad supply and spare line high
  localparam logic [VEC_W-1:0] RUN_VEC = 5'b00011;

  typedef logic [INSTR_W-1:0] instr_t;

  typedef enum logic [1:0] {
    ST_AWAKE     = 2'd0,
    ST_SLEEP_RUN = 2'd1,
    ST_ASLEEP    = 2'd2,
    ST_WAKE_RUN  = 2'd3
  } seq_state_t;

  function automatic logic [EXP_W-1:0] instr_exp(instr_t ins);
    return ins[EXP_W-1:0];
  endfunction

  function automatic logic [VEC_W-1:0] instr_vec(instr_t ins);
    return ins[INSTR_W-1:EXP_W];
  endfunction

  // counter load for a wait of 2^exp cycles
  function automatic logic [CNT_W-1:0] delay_ticks(instr_t ins);
    return (CNT_W'(1) << instr_exp(ins)) - CNT_W'(1);
  endfunction

  function automatic instr_t default_sleep(int idx);
    case (idx)
      0:       return 9'h0f0;
      1:       return 9'h1f0;
      2:       return 9'h1d0;
      default: return 9'h1c0;
    endcase
  endfunction

  function automatic instr_t default_wake(int idx);
    case (idx)
      0:       return 9'h1f0;
      1:       return 9'h0f8;
      default: return 9'h030;
    endcase
  endfunction
endpackage

// File: rtl/pwr_seq_regs.sv
`timescale 1ns/1ps
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int NUM_EVT   = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int KEY_VALUE = 32'h0051F15E
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_EVT-1:0]            cause,
  output logic [DATA_W-1:0]             rdata,
  output instr_t [PROG_LEN-1:0]         sleep_prog,
  output instr_t [PROG_LEN-1:0]         wake_prog,
  output logic [NUM_EVT-1:0]            wake_mask,
  output logic                          unlocked,
  output logic                          wr_accept,
  output logic                          trig_wr
);
  logic key_wr;

  assign key_wr    = wr_en && (addr == ADDR_W'(A_KEY));
  assign wr_accept = wr_en && !key_wr && unlocked;
  assign trig_wr   = wr_accept && (addr == ADDR_W'(A_TRIG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wdata == DATA_W'(KEY_VALUE));
    else if (wr_en)  unlocked <= 1'b0;
  end

  for (genvar i = 0; i < PROG_LEN; i++) begin : g_prog
    instr_t s_q, w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= default_sleep(i);
        w_q <= default_wake(i);
      end else if (wr_accept) begin
        if (addr == ADDR_W'(A_SLEEP0 + i)) s_q <= wdata[INSTR_W-1:0];
        if (addr == ADDR_W'(A_WAKE0 + i))  w_q <= wdata[INSTR_W-1:0];
      end
    end
    assign sleep_prog[i] = s_q;
    assign wake_prog[i]  = w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_mask <= '0;
    else if (wr_accept && addr == ADDR_W'(A_MASK)) wake_mask <= wdata[NUM_EVT-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(A_WAKE0))
      rdata[INSTR_W-1:0] = sleep_prog[addr[PIDX_W-1:0]];
    else if (addr < ADDR_W'(A_KEY))
      rdata[INSTR_W-1:0] = wake_prog[addr[PIDX_W-1:0]];
    else if (addr == ADDR_W'(A_KEY))
      rdata[0] = unlocked;
    else if (addr == ADDR_W'(A_MASK))
      rdata[NUM_EVT-1:0] = wake_mask;
    else if (addr == ADDR_W'(A_CAUSE))
      rdata[NUM_EVT-1:0] = cause;
  end
endmodule

// File: rtl/pwr_seq_wake.sv
`timescale 1ns/1ps
module pwr_seq_wake #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] mask,
  input  logic               is_asleep,
  output logic               wake_start,
  output logic [NUM_EVT-1:0] cause
);
  logic [NUM_EVT-1:0] hits;

  assign hits       = evt & mask;
  assign wake_start = is_asleep && (|hits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cause <= '0;
    else if (wake_start) cause <= hits;
  end
endmodule

// File: rtl/pwr_seq_engine.sv
`timescale 1ns/1ps
module pwr_seq_engine
  import pwr_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sleep_req,
  input  logic                  wake_start,
  input  instr_t [PROG_LEN-1:0] sleep_prog,
  input  instr_t [PROG_LEN-1:0] wake_prog,
  output logic [VEC_W-1:0]      ctl_vec,
  output logic                  sleep_start,
  output logic                  step_done,
  output logic                  is_busy,
  output logic                  is_asleep
);
  seq_state_t        state;
  logic [PIDX_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  instr_t            cur_ins, nxt_ins;
  logic              last_step;

  assign is_busy     = (state == ST_SLEEP_RUN) || (state == ST_WAKE_RUN);
  assign is_asleep   = (state == ST_ASLEEP);
  assign sleep_start = sleep_req && (state == ST_AWAKE);
  assign step_done   = is_busy && (cnt == '0);
  assign last_step   = (step == PIDX_W'(PROG_LEN - 1));
  assign cur_ins     = (state == ST_WAKE_RUN) ? wake_prog[step] : sleep_prog[step];
  assign nxt_ins     = (state == ST_WAKE_RUN) ? wake_prog[step + 1'b1]
                                               : sleep_prog[step + 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_AWAKE;
      step    <= '0;
      cnt     <= '0;
      ctl_vec <= RUN_VEC;
    end else if (sleep_start) begin
      state <= ST_SLEEP_RUN;
      step  <= '0;
      cnt   <= delay_ticks(sleep_prog[0]);
    end else if (wake_start) begin
      state <= ST_WAKE_RUN;
      step  <= '0;
      cnt   <= delay_ticks(wake_prog[0]);
    end else if (step_done) begin
      ctl_vec <= instr_vec(cur_ins);
      if (last_step) begin
        state <= (state == ST_SLEEP_RUN) ? ST_ASLEEP : ST_AWAKE;
        step  <= '0;
      end else begin
        step <= step + 1'b1;
        cnt  <= delay_ticks(nxt_ins);
      end
    end else if (is_busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int NUM_EVT   = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int KEY_VALUE = 32'h0051F15E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] wake_evt,
  output logic               clkdom_rst,
  output logic               core_rst,
  output logic               pad_rst,
  output logic               pad_pwr_en,
  output logic               spare_ctl,
  output logic               asleep,
  output logic               busy
);
  instr_t [PROG_LEN-1:0] sleep_prog, wake_prog;
  logic [NUM_EVT-1:0]    wake_mask, cause;
  logic                  unlocked, wr_accept, trig_wr;
  logic                  wake_start, sleep_start, step_done;
  logic [VEC_W-1:0]      ctl_vec;

  pwr_seq_regs #(
    .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cause(cause), .rdata(reg_rdata), .sleep_prog(sleep_prog), .wake_prog(wake_prog),
    .wake_mask(wake_mask), .unlocked(unlocked), .wr_accept(wr_accept), .trig_wr(trig_wr)
  );

  pwr_seq_wake #(.NUM_EVT(NUM_EVT)) u_wake (
    .clk(clk), .rst_n(rst_n), .evt(wake_evt), .mask(wake_mask),
    .is_asleep(asleep), .wake_start(wake_start), .cause(cause)
  );

  pwr_seq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sleep_req(trig_wr), .wake_start(wake_start),
    .sleep_prog(sleep_prog), .wake_prog(wake_prog), .ctl_vec(ctl_vec),
    .sleep_start(sleep_start), .step_done(step_done), .is_busy(busy), .is_asleep(asleep)
  );

  assign {clkdom_rst, core_rst, pad_rst, pad_pwr_en, spare_ctl} = ctl_vec;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               unlocked,
  input logic               sleep_start,
  input logic               wake_start,
  input logic               step_done,
  input logic               busy,
  input logic               asleep,
  input logic [VEC_W-1:0]   ctl_vec,
  input logic [NUM_EVT-1:0] cause
);
  // R5
  unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr != ADDR_W'(A_KEY) |=> !unlocked);

  // R6
  locked_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !unlocked && reg_addr == ADDR_W'(A_TRIG) && !busy && !asleep |=> !busy);

  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done |=> $stable(ctl_vec));

  // R7
  sleep_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_start |=> busy && !asleep);

  // R8
  asleep_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && reg_wr && reg_addr == ADDR_W'(A_TRIG) && !wake_start |=> asleep);

  // R9
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |=> busy && cause != '0);

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |=> $stable(cause));

  // R10
  state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && asleep));
endmodule

bind pwr_seq_top pwr_seq_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .unlocked(unlocked),
  .sleep_start(sleep_start), .wake_start(wake_start), .step_done(step_done),
  .busy(busy), .asleep(asleep), .ctl_vec(ctl_vec), .cause(cause)
);

// File: tb/pwr_seq_top_test.sv
`timescale 1ns/1ps
module pwr_seq_top_test;
  localparam int NEV = 8;
  localparam logic [31:0] KEY = 32'h0051F15E;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NEV-1:0] wake_evt = '0;
  logic clkdom_rst, core_rst, pad_rst, pad_pwr_en, spare_ctl, asleep, busy;
  logic [4:0] outs;

  pwr_seq_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake_evt(wake_evt), .clkdom_rst(clkdom_rst), .core_rst(core_rst),
    .pad_rst(pad_rst), .pad_pwr_en(pad_pwr_en), .spare_ctl(spare_ctl), .asleep(asleep), .busy(busy)
  );

  assign outs = {clkdom_rst, core_rst, pad_rst, pad_pwr_en, spare_ctl};
  always #2.5 clk = ~clk;

  typedef struct { int t; logic [4:0] v; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0, ncount = 0;
  bit mon_on = 0, done = 0;
  logic [4:0] last_outs;
  logic [8:0] sprog [8];
  logic [8:0] wprog [8];
  logic [4:0] model_vec;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: every output change must match the head of the scoreboard
  always @(negedge clk) begin
    ncount++;
    if (mon_on && outs !== last_outs) begin
      if (q.size() == 0) chk(1'b0, "R8/R11 unexpected output change", 32'(outs), 32'(last_outs));
      else begin
        exp_t e;
        e = q.pop_front();
        chk(outs === e.v, "R3 output vector", 32'(outs), 32'(e.v));
        chk(ncount == e.t, "R3 change cycle", 32'(ncount), 32'(e.t));
      end
    end
    last_outs = outs;
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic keyed_write(input logic [4:0] a, input logic [31:0] d);
    bus_write(5'd16, KEY);
    bus_write(a, d);
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic set_sleep(input int i, input logic [8:0] v);
    keyed_write(5'(i), 32'(v)); sprog[i] = v;
  endtask

  task automatic set_wake(input int i, input logic [8:0] v);
    keyed_write(5'(8 + i), 32'(v)); wprog[i] = v;
  endtask

  // driver: start a program and push every expected output change
  task automatic start_prog(input bit wake, input logic [NEV-1:0] evt, output int t_end);
    int n0, cum;
    @(posedge clk); #1;
    n0 = ncount;
    if (wake) wake_evt = evt;
    else begin reg_wr = 1'b1; reg_addr = 5'd17; reg_wdata = 32'hA5; end
    cum = 0;
    for (int i = 0; i < 8; i++) begin
      logic [8:0] ins;
      exp_t e;
      ins = wake ? wprog[i] : sprog[i];
      cum += (1 << ins[3:0]);
      if (ins[8:4] != model_vec) begin
        e.t = n0 + 2 + cum; e.v = ins[8:4];
        q.push_back(e);
        model_vec = ins[8:4];
      end
    end
    t_end = n0 + 2 + cum;
    @(posedge clk); #1;
    reg_wr = 1'b0; wake_evt = '0;
  endtask

  task automatic wait_to(input int n);
    while (ncount < n) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int tend;
    for (int i = 0; i < 8; i++) begin
      sprog[i] = (i == 0) ? 9'h0f0 : (i == 1) ? 9'h1f0 : (i == 2) ? 9'h1d0 : 9'h1c0;
      wprog[i] = (i == 0) ? 9'h1f0 : (i == 1) ? 9'h0f8 : 9'h030;
    end
    model_vec = 5'b00011;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(outs === 5'b00011, "R1 reset outputs", 32'(outs), 32'h3);
    chk(busy === 1'b0 && asleep === 1'b0, "R1 reset busy/asleep", {busy, asleep}, 0);
    bus_read(5'd16, rd); chk(rd == 0, "R1 unlock after reset", rd, 0);
    // R4 default programs
    for (int i = 0; i < 8; i++) begin
      bus_read(5'(i), rd);     chk(rd == 32'(sprog[i]), "R4 default sleep entry", rd, 32'(sprog[i]));
      bus_read(5'(8 + i), rd); chk(rd == 32'(wprog[i]), "R4 default wake entry", rd, 32'(wprog[i]));
    end
    last_outs = outs; mon_on = 1;

    // R6 locked writes ignored
    bus_write(5'd1, 32'h111);
    bus_read(5'd1, rd); chk(rd == 32'h1f0, "R6 locked instruction write", rd, 32'h1f0);
    bus_write(5'd17, 32'h1);
    @(posedge clk); #1;
    chk(busy === 1'b0 && asleep === 1'b0, "R6 locked trigger", {busy, asleep}, 0);

    // R5 unlock handling
    bus_write(5'd16, KEY);
    bus_read(5'd16, rd); chk(rd == 1, "R5 key sets unlock", rd, 1);
    bus_write(5'd18, 32'h0);
    bus_read(5'd16, rd); chk(rd == 0, "R5 write clears unlock", rd, 0);
    bus_write(5'd16, KEY);
    bus_write(5'd16, 32'h0051F15F);
    bus_read(5'd16, rd); chk(rd == 0, "R5 wrong key clears unlock", rd, 0);
    bus_write(5'd16, KEY);
    bus_write(5'd19, 32'hFF);
    bus_write(5'd18, 32'h1);
    bus_read(5'd18, rd); chk(rd == 0, "R5 unlock spent by failed write", rd, 0);

    // R2 upper instruction bits dropped
    keyed_write(5'd15, 32'hFFFF_F030);
    bus_read(5'd15, rd); chk(rd == 32'h030, "R2 upper bits not stored", rd, 32'h030);

    // R7 default sleep program
    bus_write(5'd16, KEY);
    start_prog(1'b0, '0, tend);
    chk(busy === 1'b1, "R7 busy during sleep program", 32'(busy), 1);
    wait_to(tend);
    chk(q.size() == 0, "R7 all sleep steps seen", q.size(), 0);
    chk(asleep === 1'b1 && busy === 1'b0, "R7 asleep after program", {busy, asleep}, 1);

    // R8 trigger while asleep
    keyed_write(5'd17, 32'h0);
    repeat (4) @(posedge clk); #1;
    chk(asleep === 1'b1 && busy === 1'b0, "R8 trigger while asleep", {busy, asleep}, 1);

    // R9 masked-off event ignored
    keyed_write(5'd18, 32'h04);
    wake_evt = 8'h01; repeat (3) @(posedge clk); #1; wake_evt = '0;
    chk(asleep === 1'b1, "R9 masked event ignored", 32'(asleep), 1);
    bus_read(5'd19, rd); chk(rd == 0, "R9 cause untouched", rd, 0);

    // R9/R10 enabled event runs default wake program
    start_prog(1'b1, 8'h05, tend);
    bus_read(5'd19, rd); chk(rd == 32'h04, "R9 cause records masked events", rd, 32'h04);
    wait_to(tend);
    chk(q.size() == 0, "R10 all wake steps seen", q.size(), 0);
    chk(asleep === 1'b0 && busy === 1'b0, "R10 awake after wake program", {busy, asleep}, 0);

    // R11 events while awake
    wake_evt = 8'hFF; repeat (3) @(posedge clk); #1; wake_evt = '0;
    chk(busy === 1'b0 && asleep === 1'b0, "R11 event while awake", {busy, asleep}, 0);
    bus_read(5'd19, rd); chk(rd == 32'h04, "R11 cause held", rd, 32'h04);

    // R3 custom delays, R8 trigger mid-run, R11 event mid-run
    set_sleep(0, 9'h103); set_sleep(1, 9'h185); set_sleep(2, 9'h1c0); set_sleep(3, 9'h1c0);
    set_sleep(4, 9'h1e2); set_sleep(5, 9'h1e0); set_sleep(6, 9'h1f1); set_sleep(7, 9'h1d4);
    set_wake(0, 9'h1f2); set_wake(1, 9'h0f3); set_wake(2, 9'h0b1); set_wake(3, 9'h038);
    keyed_write(5'd18, 32'h0C);
    bus_write(5'd16, KEY);
    start_prog(1'b0, '0, tend);
    repeat (10) @(posedge clk);
    keyed_write(5'd17, 32'h1);
    wake_evt = 8'h0C; repeat (2) @(posedge clk); #1; wake_evt = '0;
    chk(busy === 1'b1, "R8 still running after mid-run trigger", 32'(busy), 1);
    wait_to(tend);
    chk(q.size() == 0, "R3 custom sleep steps seen", q.size(), 0);
    chk(asleep === 1'b1, "R7 asleep after custom program", 32'(asleep), 1);
    bus_read(5'd19, rd); chk(rd == 32'h04, "R11 cause unchanged by mid-run event", rd, 32'h04);

    start_prog(1'b1, 8'h0C, tend);
    wait_to(tend);
    chk(q.size() == 0, "R10 custom wake steps seen", q.size(), 0);
    bus_read(5'd19, rd); chk(rd == 32'h0C, "R9 cause from second wake", rd, 32'h0C);
    chk(outs === 5'b00011 && busy === 1'b0, "R10 final outputs", 32'(outs), 32'h3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule